// File: doc/BRIEF.md
# SMBus Timeout and Alert Supervisor

This block sits beside an SMBus-capable I2C controller and reacts to two kinds of fault. When the controller's interval timer flags an expired timeout, the block acts according to the current role. As master it issues a one-cycle request to send a STOP condition. As slave it holds a release command that makes the controller stop driving SDA and SCL low. Both roles set a sticky timeout status bit.

A second path watches the SMBA alert line. The line passes through a synchronizer and then an edge detector. A falling edge latches a sticky alert status bit, but only when host operation and alert detection are both enabled.

Software clears each status bit with its own strobe. The error interrupt is the OR of the two bits, gated by an interrupt enable.

Top module: `smb_fault_supervisor`

## Requirements
- R1: A cycle with `tmo_det`=1 and `role_master`=1 (1 means master) gives `stop_req`=1 in the following cycle. `stop_req` is 0 in every cycle that does not follow such a cycle.
- R2: A cycle with `tmo_det`=1 and `role_master`=0 gives `bus_release`=1 from the next cycle. `bus_release` then stays 1 until the clock edge after a cycle with `bus_idle_ack`=1 and no new slave timeout. If a slave timeout and `bus_idle_ack` arrive in the same cycle, the timeout wins.
- R3: Any cycle with `tmo_det`=1 sets `tmo_flag` from the next cycle, whatever the role.
- R4: `alert_flag` sets on the edge after the synchronized SMBA level goes from 1 to 0, provided `host_en`=1 and `alert_det_en`=1 in that cycle. With the default SYNC_STAGES=2, this is three clock edges after `smba_in` falls.
- R5: A synchronized SMBA falling edge seen while `host_en` or `alert_det_en` is 0 is discarded. Enabling detection later does not set `alert_flag` for that edge.
- R6: `tmo_flag` and `alert_flag` are sticky. `clr_tmo` clears only `tmo_flag`, and `clr_alert` clears only `alert_flag`, each on the next edge. A set event in the same cycle as a clear wins.
- R7: `err_irq` equals `err_irq_en` AND (`tmo_flag` OR `alert_flag`) with no register delay.
- R8: A synchronous active-high `rst` clears `stop_req`, `bus_release`, `tmo_flag` and `alert_flag`, and loads the synchronizer history with 1. Releasing reset while `smba_in` is high never sets `alert_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| host_en | input | 1 | Host operation enabled |
| alert_det_en | input | 1 | Alert line detection enabled |
| err_irq_en | input | 1 | Error interrupt enable |
| tmo_det | input | 1 | Timeout detected strobe from the interval timer |
| smba_in | input | 1 | Asynchronous SMBA alert line, idle high |
| bus_idle_ack | input | 1 | Controller reports the bus is back to idle |
| clr_tmo | input | 1 | Software clear strobe for the timeout flag |
| clr_alert | input | 1 | Software clear strobe for the alert flag |
| stop_req | output | 1 | One-cycle STOP condition request |
| bus_release | output | 1 | Release SDA and SCL |
| tmo_flag | output | 1 | Sticky timeout status |
| alert_flag | output | 1 | Sticky alert status |
| err_irq | output | 1 | Error interrupt |

## Verification
The embedded assertions check the following every cycle:
- the role-dependent reaction to a timeout;
- that a timeout always sets its flag;
- that both flags stay set without a clear;
- that a rising alert flag needs both enables;
- that the interrupt never fires with its enable off.

Some behaviour only the bench scenarios can show: the exact synchronizer latency, that an edge is discarded while detection is disabled, that set beats clear when both arrive together, and that leaving reset with SMBA held high or low behaves correctly. The bench's reference model tracks these on every clock.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } bus_role_e;

    typedef struct packed {
        logic tmo;
        logic alert;
    } fault_flags_t;

    function automatic logic irq_of(input fault_flags_t f, input logic en);
        return en & (f.tmo | f.alert);
    endfunction

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        if (set)      return 1'b1;
        else if (clr) return 1'b0;
        else          return cur;
    endfunction

endpackage

// File: rtl/smba_edge_sync.sv
module smba_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic fall_seen
);
    localparam int HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '1;
        end else begin
            hist[0] <= line_in;
            for (int k = 1; k < HIST_W; k++) begin
                hist[k] <= hist[k-1];
            end
        end
    end

    assign fall_seen = hist[HIST_W-1] & ~hist[HIST_W-2];

endmodule

// File: rtl/timeout_reactor.sv
module timeout_reactor
    import smb_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_role_e role,
    input  logic      tmo_det,
    input  logic      idle_ack,
    output logic      stop_pulse,
    output logic      release_hold
);
    logic tmo_master, tmo_slave;

    assign tmo_master = tmo_det & (role == ROLE_MASTER);
    assign tmo_slave  = tmo_det & (role == ROLE_SLAVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_pulse   <= 1'b0;
            release_hold <= 1'b0;
        end else begin
            stop_pulse   <= tmo_master;
            release_hold <= sticky_next(release_hold, tmo_slave, idle_ack);
        end
    end

    AST_STOP_FROM_MASTER_TMO: assert property (@(posedge clk) disable iff (rst)
        (tmo_det && role == ROLE_MASTER) |=> stop_pulse); // R1
    AST_STOP_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !(tmo_det && role == ROLE_MASTER) |=> !stop_pulse); // R1
    AST_RELEASE_ON_SLAVE_TMO: assert property (@(posedge clk) disable iff (rst)
        (tmo_det && role == ROLE_SLAVE) |=> release_hold); // R2
    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (rst)
        (release_hold && !idle_ack) |=> release_hold); // R2

endmodule

// File: rtl/fault_status.sv
module fault_status
    import smb_mon_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tmo_set,
    input  logic         alert_set,
    input  logic         tmo_clr,
    input  logic         alert_clr,
    input  logic         irq_en,
    output fault_flags_t flags,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.tmo   <= sticky_next(flags.tmo, tmo_set, tmo_clr);
            flags.alert <= sticky_next(flags.alert, alert_set, alert_clr);
        end
    end

    assign irq = irq_of(flags, irq_en);

    AST_TMO_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        tmo_set |=> flags.tmo); // R3
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.tmo && !tmo_clr) |=> flags.tmo); // R6
    AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.alert && !alert_clr) |=> flags.alert); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en); // R7

endmodule

// File: rtl/smb_fault_supervisor.sv
module smb_fault_supervisor
    import smb_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic role_master,
    input  logic host_en,
    input  logic alert_det_en,
    input  logic err_irq_en,
    input  logic tmo_det,
    input  logic smba_in,
    input  logic bus_idle_ack,
    input  logic clr_tmo,
    input  logic clr_alert,
    output logic stop_req,
    output logic bus_release,
    output logic tmo_flag,
    output logic alert_flag,
    output logic err_irq
);
    bus_role_e    role;
    logic         smba_fall;
    logic         alert_arm;
    fault_flags_t flags;

    assign role      = role_master ? ROLE_MASTER : ROLE_SLAVE;
    assign alert_arm = smba_fall & host_en & alert_det_en;

    smba_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_in   (smba_in),
        .fall_seen (smba_fall)
    );

    timeout_reactor u_react (
        .clk          (clk),
        .rst          (rst),
        .role         (role),
        .tmo_det      (tmo_det),
        .idle_ack     (bus_idle_ack),
        .stop_pulse   (stop_req),
        .release_hold (bus_release)
    );

    fault_status u_status (
        .clk       (clk),
        .rst       (rst),
        .tmo_set   (tmo_det),
        .alert_set (alert_arm),
        .tmo_clr   (clr_tmo),
        .alert_clr (clr_alert),
        .irq_en    (err_irq_en),
        .flags     (flags),
        .irq       (err_irq)
    );

    assign tmo_flag   = flags.tmo;
    assign alert_flag = flags.alert;

    AST_ALERT_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_flag) |-> $past(host_en && alert_det_en)); // R4

endmodule

// File: tb/test_smb_fault_supervisor.sv
module test_smb_fault_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int NSYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_master = 1'b0, host_en = 1'b0, alert_det_en = 1'b0, err_irq_en = 1'b0;
    logic tmo_det = 1'b0, smba_in = 1'b1, bus_idle_ack = 1'b0, clr_tmo = 1'b0, clr_alert = 1'b0;
    logic stop_req, bus_release, tmo_flag, alert_flag, err_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    bit m_stop = 0, m_rel = 0, m_tmo = 0, m_al = 0;
    bit hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_fault_supervisor #(.SYNC_STAGES(NSYNC)) i_smb_fault_supervisor (
        .clk(clk), .rst(rst), .role_master(role_master), .host_en(host_en),
        .alert_det_en(alert_det_en), .err_irq_en(err_irq_en), .tmo_det(tmo_det),
        .smba_in(smba_in), .bus_idle_ack(bus_idle_ack), .clr_tmo(clr_tmo),
        .clr_alert(clr_alert), .stop_req(stop_req), .bus_release(bus_release),
        .tmo_flag(tmo_flag), .alert_flag(alert_flag), .err_irq(err_irq)
    );

    // Behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        bit fall;
        cycles++;
        if (rst) begin
            m_stop = 0; m_rel = 0; m_tmo = 0; m_al = 0;
            hist = {};
            for (int i = 0; i <= NSYNC; i++) hist.push_back(1'b1);
        end else begin
            fall = hist[NSYNC] && !hist[NSYNC-1];
            m_stop = tmo_det && role_master;
            if (tmo_det && !role_master) m_rel = 1;
            else if (bus_idle_ack) m_rel = 0;
            if (tmo_det) m_tmo = 1;
            else if (clr_tmo) m_tmo = 0;
            if (fall && host_en && alert_det_en) m_al = 1;
            else if (clr_alert) m_al = 0;
            hist.push_front(smba_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cycles, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk("R1 stop_req",    stop_req,    m_stop);
            chk("R2 bus_release", bus_release, m_rel);
            chk("R3 tmo_flag",    tmo_flag,    m_tmo);
            chk("R4 alert_flag",  alert_flag,  m_al);
            chk("R7 err_irq",     err_irq,     err_irq_en & (m_tmo | m_al));
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tmo(input logic master);
        role_master = master; tmo_det = 1'b1; step(); tmo_det = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();
        // R8: reset state after leaving reset with SMBA high
        chk("R8 reset stop", stop_req, 1'b0);
        chk("R8 reset rel", bus_release, 1'b0);
        chk("R8 reset flags", tmo_flag | alert_flag, 1'b0);
        host_en = 1; alert_det_en = 1; step(4);
        chk("R8 no false alert", alert_flag, 1'b0);

        // R1: master timeout -> single stop pulse
        pulse_tmo(1'b1);
        chk("R1 stop pulse", stop_req, 1'b1);
        chk("R3 tmo set master", tmo_flag, 1'b1);
        step();
        chk("R1 stop one cycle", stop_req, 1'b0);
        chk("R2 no release in master", bus_release, 1'b0);

        // R7: interrupt gating
        chk("R7 irq off", err_irq, 1'b0);
        err_irq_en = 1; #1;
        chk("R7 irq on", err_irq, 1'b1);

        // R6: clear timeout flag
        clr_tmo = 1; step(); clr_tmo = 0;
        chk("R6 tmo cleared", tmo_flag, 1'b0);

        // R2: slave timeout holds release until ack
        pulse_tmo(1'b0);
        chk("R2 release set", bus_release, 1'b1);
        chk("R1 no stop in slave", stop_req, 1'b0);
        step(5);
        chk("R2 release held", bus_release, 1'b1);
        bus_idle_ack = 1; tmo_det = 1; step();
        chk("R2 set beats ack", bus_release, 1'b1);
        tmo_det = 0; step(); bus_idle_ack = 0;
        chk("R2 released on ack", bus_release, 1'b0);

        // R6: set beats clear
        clr_tmo = 1; tmo_det = 1; step(); clr_tmo = 0; tmo_det = 0;
        chk("R6 set priority", tmo_flag, 1'b1);
        clr_tmo = 1; step(); clr_tmo = 0;

        // R4: alert latency SYNC_STAGES+1 edges
        smba_in = 0; step(NSYNC);
        chk("R4 not yet", alert_flag, 1'b0);
        step();
        chk("R4 alert set", alert_flag, 1'b1);
        chk("R6 tmo unaffected by alert", tmo_flag, 1'b0);
        clr_alert = 1; step(); clr_alert = 0;
        chk("R6 alert cleared", alert_flag, 1'b0);
        smba_in = 1; step(4);

        // R5: edge while disabled is discarded
        alert_det_en = 0; smba_in = 0; step(NSYNC + 1);
        alert_det_en = 1; step(4);
        chk("R5 discarded edge", alert_flag, 1'b0);
        smba_in = 1; host_en = 0; step(3); smba_in = 0; step(4);
        chk("R5 host off", alert_flag, 1'b0);
        host_en = 1; smba_in = 1; step(4);

        // R8: reset with SMBA low, then release
        rst = 1; smba_in = 0; step(2); rst = 0; step(4);
        chk("R8 reset clears", tmo_flag | bus_release, 1'b0);
        smba_in = 1; step(4);

        // Mixed stimulus compared against the model each cycle
        for (int i = 0; i < 3000; i++) begin
            role_master  = 1'($urandom_range(0, 1));
            host_en      = ($urandom_range(0, 7) != 0);
            alert_det_en = ($urandom_range(0, 7) != 0);
            err_irq_en   = 1'($urandom_range(0, 1));
            tmo_det      = ($urandom_range(0, 15) == 0);
            bus_idle_ack = ($urandom_range(0, 7) == 0);
            clr_tmo      = ($urandom_range(0, 7) == 0);
            clr_alert    = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) smba_in = ~smba_in;
            step();
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule